// File: doc/BRIEF.md
# Isolation Gate Unlock Sequencer

This block guards transfers into an always-on power domain. Software writes a fixed seven-value unlock code, one value per write, into a small isolation control field. Each correctly accepted value is answered on an acknowledge output whose level gives the parity of the accepted step. That answer reaches the output only after a fixed number of extra register stages, which stand in for the crossing into the slow domain. When the seventh value is accepted, the block opens an isolation-enable window of a fixed number of clock cycles. It also issues a one-cycle transfer strobe that tells the always-on register bank to take its pending data.

The controller is a three-state machine. `ST_SEEK` tracks the index of the next expected code value. `ST_FIRE` is the single first cycle of the open window, in which the strobe is high. `ST_HOLD` covers the remaining window cycles. The transitions are named as follows. Seek-accept stays in `ST_SEEK` and advances the index. Seek-restart stays in `ST_SEEK` with the index at 1. Seek-reject stays in `ST_SEEK` with the index at 0. Seek-complete goes from `ST_SEEK` to `ST_FIRE`. Fire-to-hold goes from `ST_FIRE` to `ST_HOLD`. Window-close goes from `ST_FIRE` or `ST_HOLD` back to `ST_SEEK` once the window counter is spent.

Top module: `iso_gate_hs`

## Requirements
- R1: While reset is held and directly after it, `ack`, `iso_en` and `xfer_stb` are 0, and the next expected code index is 0.
- R2: The unlock code is the values 0, 1, 3, 7, 5, 1, 0 in that order. When the value at index i (0 to 6) is accepted, the acknowledge target becomes i mod 2, so the acknowledge reads 0, 1, 0, 1, 0, 1, 0 across the seven steps.
- R3: A change of the acknowledge target appears on `ack` after ACK_DELAY rising edges, counting the edge that samples the write. Until then `ack` keeps its previous value.
- R4: Only `wr_data[2:0]` is compared against the code. The upper bits of a write have no effect.
- R5: A write in `ST_SEEK` whose value is neither the expected one nor 0 returns the index to 0 and leaves the acknowledge unchanged.
- R6: A write of 0 that is not the expected value counts as an accepted step 0. The acknowledge target becomes 0 and the next expected index is 1.
- R7: Accepting the seventh value opens a window in which `iso_en` is 1 for exactly EN_CYCLES consecutive cycles, starting in the cycle after the sampling edge.
- R8: `xfer_stb` is high for exactly one cycle, the first cycle of each window, and never at any other time.
- R9: Writes presented while the window is open are ignored, for both the acknowledge and the index. When the window closes, the index is 0.
- R10: Idle cycles between writes do not change the index, so a sequence spread over many cycles still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write to the isolation control field this cycle |
| wr_data | input | DATA_W | Written value; only bits [2:0] are used |
| ack | output | 1 | Delayed step-parity acknowledge |
| iso_en | output | 1 | Isolation-enable window level |
| xfer_stb | output | 1 | One-cycle transfer strobe on window open |

## Verification
The bench targets the following corner cases.

- **Restart write of 0 after step 1.** A design that only rewinds here, instead of accepting step 0, would leave `ack` stuck at 1. A later complete code would then still open the window, but the acknowledge mismatch is caught.
- **Wrong nonzero value while `ack` is 1.** A design that clears the acknowledge on a reject would show 0 here.
- **Writes of 0 and 1 while the window is open.** A design that does not ignore them would raise `ack` to 1.
- **Code written without its leading 0.** A design that does not reset the index would open a window it should not.
- **Window length and strobe.** These are compared against the reference model on every cycle, so an off-by-one window or a strobe of two cycles shows at once.
- **Upper data bits set.** A design that compares the full byte would never unlock.

// File: rtl/iso_gate_pkg.sv
package iso_gate_pkg;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } gate_state_e;

    localparam int CODE_LEN = 7;
    localparam int STEP_W   = 3;
    localparam int VAL_W    = 3;

    // Unlock code value expected at each step index
    function automatic logic [VAL_W-1:0] code_at(input logic [STEP_W-1:0] idx);
        logic [VAL_W-1:0] v;
        unique case (idx)
            3'd0:    v = 3'd0;
            3'd1:    v = 3'd1;
            3'd2:    v = 3'd3;
            3'd3:    v = 3'd7;
            3'd4:    v = 3'd5;
            3'd5:    v = 3'd1;
            3'd6:    v = 3'd0;
            default: v = 3'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/iso_gate_match.sv
module iso_gate_match
    import iso_gate_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [VAL_W-1:0]  val,
    output logic              hit,
    output logic              restart,
    output logic              last
);

    logic [VAL_W-1:0] expect_v;

    always_comb begin
        expect_v = code_at(step);
        hit      = (val == expect_v);
        // A mismatching 0 is taken as the first step of a new attempt
        restart  = !hit && (val == code_at('0));
        last     = hit && (step == STEP_W'(CODE_LEN - 1));
    end

endmodule

// File: rtl/iso_gate_ack_delay.sv
module iso_gate_ack_delay #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            logic [STAGES-1:0] sr;
            for (genvar g = 0; g < STAGES; g++) begin : g_stage
                if (g == 0) begin : g_head
                    always_ff @(posedge clk or negedge rst_n) begin
                        if (!rst_n) sr[0] <= 1'b0;
                        else        sr[0] <= d;
                    end
                end else begin : g_body
                    always_ff @(posedge clk or negedge rst_n) begin
                        if (!rst_n) sr[g] <= 1'b0;
                        else        sr[g] <= sr[g-1];
                    end
                end
            end
            assign q = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/iso_gate_hs.sv
module iso_gate_hs
    import iso_gate_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ACK_DELAY = 3,
    parameter int EN_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ack,
    output logic              iso_en,
    output logic              xfer_stb
);

    localparam int CNT_W    = $clog2(EN_CYCLES + 1);
    localparam int XTRA_STG = (ACK_DELAY > 0) ? ACK_DELAY - 1 : 0;

    gate_state_e        state, state_n;
    logic [STEP_W-1:0]  step, step_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic               ack_tgt, ack_tgt_n;

    logic hit, restart, last;

    iso_gate_match u_match (
        .step    (step),
        .val     (wr_data[VAL_W-1:0]),
        .hit     (hit),
        .restart (restart),
        .last    (last)
    );

    iso_gate_ack_delay #(.STAGES(XTRA_STG)) u_ack_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgt),
        .q     (ack)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_SEEK;
            step    <= '0;
            cnt     <= '0;
            ack_tgt <= 1'b0;
        end else begin
            state   <= state_n;
            step    <= step_n;
            cnt     <= cnt_n;
            ack_tgt <= ack_tgt_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n   = state;
        step_n    = step;
        cnt_n     = cnt;
        ack_tgt_n = ack_tgt;
        unique case (state)
            ST_SEEK: begin
                if (wr_en) begin
                    if (hit) begin
                        ack_tgt_n = step[0];
                        if (last) begin
                            state_n = ST_FIRE;
                            step_n  = '0;
                            cnt_n   = CNT_W'(EN_CYCLES - 1);
                        end else begin
                            step_n  = step + 1'b1;
                        end
                    end else if (restart) begin
                        ack_tgt_n = 1'b0;
                        step_n    = STEP_W'(1);
                    end else begin
                        step_n    = '0;
                    end
                end
            end
            ST_FIRE, ST_HOLD: begin
                if (cnt == '0) begin
                    state_n = ST_SEEK;
                    step_n  = '0;
                end else begin
                    state_n = ST_HOLD;
                    cnt_n   = cnt - 1'b1;
                end
            end
            default: state_n = ST_SEEK;
        endcase
    end

    // Outputs
    always_comb begin
        iso_en   = (state == ST_FIRE) || (state == ST_HOLD);
        xfer_stb = (state == ST_FIRE);
    end

endmodule

// File: rtl/iso_gate_hs_chk.sv
module iso_gate_hs_chk #(
    parameter int EN_CYCLES = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic iso_en,
    input logic xfer_stb
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= 0;
        else if (iso_en) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    // R8: strobe only in the first cycle of the window
    p_stb_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |-> (iso_en && run_len == 0));

    // R8: strobe lasts one cycle
    p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb |=> !xfer_stb);

    // R8: every window opening carries a strobe
    p_rise_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_en) |-> xfer_stb);

    // R7: window never exceeds its length
    p_window_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iso_en |-> (run_len < EN_CYCLES));

    // R7: window closes only after its full length
    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (run_len == EN_CYCLES));

endmodule

bind iso_gate_hs iso_gate_hs_chk #(.EN_CYCLES(EN_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iso_en   (iso_en),
    .xfer_stb (xfer_stb)
);

// File: tb/iso_gate_hs_tb_top.sv
`timescale 1ns/1ps
module iso_gate_hs_tb_top;

    localparam int ACK_D = 3;
    localparam int EN_C  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ack, iso_en, xfer_stb;

    iso_gate_hs #(.DATA_W(8), .ACK_DELAY(ACK_D), .EN_CYCLES(EN_C)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ack(ack), .iso_en(iso_en), .xfer_stb(xfer_stb)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int stb_seen = 0;
    bit started = 0;
    int code [7] = '{0, 1, 3, 7, 5, 1, 0};

    task automatic chk(string req, int got, int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // Behavioural reference model
    int   m_step, m_win;
    bit   m_tgt, m_stb;
    bit   m_q[$];
    int   m_v;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_win = 0; m_tgt = 0; m_stb = 0;
            m_q.delete();
            for (int i = 0; i < ACK_D; i++) m_q.push_back(1'b0);
        end else begin
            m_stb = 0;
            if (m_win > 0) begin
                m_win--;
                if (m_win == 0) m_step = 0;
            end else if (wr_en) begin
                m_v = int'(wr_data) % 8;
                if (m_v == code[m_step]) begin
                    m_tgt = (m_step % 2) == 1;
                    if (m_step == 6) begin
                        m_win = EN_C; m_stb = 1; m_step = 0;
                    end else m_step++;
                end else if (m_v == 0) begin
                    m_tgt = 0; m_step = 1;
                end else m_step = 0;
            end
            m_q.push_front(m_tgt);
            void'(m_q.pop_back());
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R3 ack", int'(ack), int'(m_q[ACK_D-1]));
            chk("R7 iso_en", int'(iso_en), (m_win > 0) ? 1 : 0);
            chk("R8 xfer_stb", int'(xfer_stb), int'(m_stb));
            if (xfer_stb) stb_seen++;
        end
    end

    task automatic wr(int v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog got=timeout exp=finished");
        summary();
        $finish;
    end

    initial begin
        int s0;
        idle(2);
        // R1: outputs during reset
        chk("R1 ack", int'(ack), 0);
        chk("R1 iso_en", int'(iso_en), 0);
        chk("R1 xfer_stb", int'(xfer_stb), 0);
        rst_n = 1'b1;
        started = 1;
        idle(2);
        chk("R1 ack after reset", int'(ack), 0);

        // R2: full code with gaps, check parity after each step
        for (int i = 0; i < 6; i++) begin
            wr(code[i]);
            idle(ACK_D);
            chk("R2 step parity", int'(ack), i % 2);
        end
        wr(code[6]);
        chk("R7 window opens", int'(iso_en), 1);
        chk("R8 strobe first cycle", int'(xfer_stb), 1);
        idle(1);
        chk("R8 strobe one cycle", int'(xfer_stb), 0);
        // R9: writes during the window are ignored
        wr(0); wr(1);
        idle(ACK_D + 1);
        chk("R9 ack unchanged in window", int'(ack), 0);
        idle(EN_C);
        chk("R7 window closed", int'(iso_en), 0);
        // R9: index is 0 after the window, so code without its leading 0 fails
        s0 = stb_seen;
        for (int i = 1; i < 7; i++) wr(code[i]);
        idle(5);
        chk("R9 no unlock without leading step", stb_seen - s0, 0);

        // R4: upper bits set, back to back
        s0 = stb_seen;
        for (int i = 0; i < 7; i++) wr(code[i] | 8'hF8);
        idle(EN_C + 5);
        chk("R4 upper bits ignored", stb_seen - s0, 1);

        // R5: wrong nonzero value keeps ack, rewinds index
        wr(0); wr(1);
        idle(ACK_D);
        chk("R5 ack before reject", int'(ack), 1);
        wr(6);
        idle(ACK_D + 1);
        chk("R5 ack kept on reject", int'(ack), 1);
        s0 = stb_seen;
        for (int i = 2; i < 7; i++) wr(code[i]);
        idle(5);
        chk("R5 no unlock after reject", stb_seen - s0, 0);

        // R6: restart on mismatching 0
        wr(0); wr(1);
        idle(ACK_D);
        chk("R6 ack before restart", int'(ack), 1);
        wr(0);
        idle(ACK_D);
        chk("R6 restart acknowledges step 0", int'(ack), 0);
        wr(1);
        idle(ACK_D);
        chk("R6 next expected is index 1", int'(ack), 1);
        s0 = stb_seen;
        for (int i = 2; i < 7; i++) wr(code[i]);
        idle(EN_C + 5);
        chk("R6 unlock after restart", stb_seen - s0, 1);

        // R10: long idle gap inside the sequence
        s0 = stb_seen;
        wr(0); wr(1); wr(3);
        idle(25);
        wr(7); wr(5); wr(1); wr(0);
        idle(EN_C + 5);
        chk("R10 unlock across idle gap", stb_seen - s0, 1);

        summary();
        $finish;
    end

endmodule